// File: doc/BRIEF.md
# Linked-List Descriptor DMA Engine

This block is a single-channel DMA engine that copies data between two address spaces, a host side and a local side, through one word-wide memory master port. Software programs it through a small register port. It can run a single block described directly by its channel registers. It can also follow a list of 16-byte descriptors kept in either space. Each descriptor supplies a host address, a local address, a byte count and a link word. The link word carries the address of the next descriptor together with per-element flags: which space that descriptor lives in, last element, interrupt on this element, and transfer direction.

Data moves in 32-bit words. For each word the engine reads from the source space and then writes to the destination space. A byte count that is not a multiple of four is rounded up to whole words. A control register starts, pauses and aborts the channel, and it exposes a completion flag. A sticky interrupt output reports completion and flagged elements. An optional mode writes zero back into each descriptor's count word once that element is finished.

Top module: `chain_dma`

## Requirements
- R1: After reset the memory request, the interrupt output, the enable and done bits and every register read back as zero.
- R2: A start moves `ceil(count/4)` words. Each word is one read of the source followed by one write of the same value to the destination. The host side is the source when the direction bit (link word bit 3) is 0, and the local side is the source when it is 1. `mem_host` is 1 for host-side accesses. A request stays asserted with stable address and write strobe until `mem_ack`, unless the control register is written.
- R3: Addresses are word aligned. The host address advances by 4 per word. The local address also advances by 4 per word, unless hold mode (mode bit 11) is set, in which case it stays constant. A count of zero produces no data access.
- R4: With chaining on (mode bit 9), a start fetches the descriptor at link register bits 31:4 times 16, reading offsets 0, 4, 8 and 12 in order, in the space given by link bit 0 (1 = host side). Host address, local address, count and link word are loaded from those offsets. The loaded link word's bits 31:4 and bit 0 locate the next descriptor.
- R5: Only the low 23 bits of a count are kept, whether written by software or fetched from a descriptor.
- R6: With chaining and zero-back mode (mode bit 16) on, each element ends with a write of zero to its descriptor's offset 8, in that descriptor's space.
- R7: The done bit (control bit 4) is set when the element whose link bit 1 is set has finished, or when the single block has finished in unchained mode, or on abort. An accepted start clears it.
- R8: The interrupt output is set on completion when mode bit 10 is set, and after any chained element whose link bit 2 is set. It is not set by an abort. It stays set until a control write with bit 3 = 1.
- R9: Writing control bit 0 = 0 while busy pauses the engine. No requests are made and no state is lost. Setting bit 0 again resumes with no word skipped or repeated.
- R10: A start (control bit 1) is ignored unless bit 0 of the same write is 1, and it is ignored while the engine is busy.
- R11: A control write with bit 2 = 1 while busy ends the run on that edge and leaves the enable bit unchanged.
- R12: While busy, writes to the mode, host, local, count and link registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 mode, 1 host address, 2 local address, 3 count, 4 link, 5 control/status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_host | output | 1 | 1 = host-side space, 0 = local-side space |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted on this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| irq | output | 1 | Sticky interrupt |

## Verification
On every cycle, the assertions check four things: requests hold stable while waiting for an acknowledge, addresses stay word aligned, a paused or idle engine stays off the port, and an abort drops the busy state and sets done. They also check that done is clear when a run begins and that the interrupt holds until it is cleared. The bench's scenarios are what show the content of the transfers. That covers the exact order of descriptor fetches and data words, the values carried across, the zero written back, the rounding of odd counts and the 23-bit truncation. They also show that an ignored start or a mid-run register write leaves the traffic unchanged, and that a pause resumes at the right word.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  localparam int WORD_W = 32;
  localparam int RSEL_W = 3;

  localparam logic [RSEL_W-1:0] RA_MODE  = 3'd0;
  localparam logic [RSEL_W-1:0] RA_HOST  = 3'd1;
  localparam logic [RSEL_W-1:0] RA_LOCAL = 3'd2;
  localparam logic [RSEL_W-1:0] RA_COUNT = 3'd3;
  localparam logic [RSEL_W-1:0] RA_LINK  = 3'd4;
  localparam logic [RSEL_W-1:0] RA_CTRL  = 3'd5;

  localparam int CB_EN    = 0;
  localparam int CB_GO    = 1;
  localparam int CB_ABORT = 2;
  localparam int CB_ICLR  = 3;
  localparam int CB_DONE  = 4;

  localparam int MB_CHAIN = 9;
  localparam int MB_DIE   = 10;
  localparam int MB_HOLD  = 11;
  localparam int MB_ZERO  = 16;

  localparam int LB_SPACE = 0;
  localparam int LB_LAST  = 1;
  localparam int LB_LINK  = 2;
  localparam int LB_DIR   = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_READ,
    ST_WRITE,
    ST_ZERO,
    ST_NEXT
  } eng_state_t;
endpackage

// File: rtl/chain_dma_engine.sv
module chain_dma_engine
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_en,
  input  logic                go,
  input  logic                stop,
  input  logic                chain_mode,
  input  logic                hold_local,
  input  logic                zero_count,
  input  logic                sw_wr,
  input  logic [RSEL_W-1:0]   sw_addr,
  input  logic [WORD_W-1:0]   sw_wdata,
  input  logic                mem_ack,
  input  logic [WORD_W-1:0]   mem_rdata,
  output logic                busy,
  output logic                fin,
  output logic                link_hit,
  output logic [ADDR_W-1:0]   host_q,
  output logic [ADDR_W-1:0]   local_q,
  output logic [CNT_W-1:0]    count_q,
  output logic [WORD_W-1:0]   link_q,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_host,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [WORD_W-1:0]   mem_wdata
);
  localparam int DESC_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(4);

  eng_state_t          state_q, state_d;
  logic [ADDR_W-1:0]   host_d, local_d;
  logic [CNT_W-1:0]    count_d;
  logic [WORD_W-1:0]   link_d;
  logic [DESC_W-1:0]   desc_q, desc_d;
  logic                dspace_q, dspace_d;
  logic [1:0]          widx_q, widx_d;
  logic [WORD_W-1:0]   data_q, data_d;
  logic                dir;
  eng_state_t          end_state;

  assign dir       = link_q[LB_DIR];
  assign end_state = (chain_mode && zero_count) ? ST_ZERO : ST_NEXT;
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    host_d   = host_q;
    local_d  = local_q;
    count_d  = count_q;
    link_d   = link_q;
    desc_d   = desc_q;
    dspace_d = dspace_q;
    widx_d   = widx_q;
    data_d   = data_q;
    fin      = 1'b0;
    link_hit = 1'b0;
    if (stop) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (go) begin
            if (chain_mode) begin
              desc_d   = link_q[ADDR_W-1:4];
              dspace_d = link_q[LB_SPACE];
              widx_d   = 2'd0;
              state_d  = ST_FETCH;
            end else begin
              state_d  = ST_CHECK;
            end
          end else if (sw_wr) begin
            unique case (sw_addr)
              RA_HOST:  host_d  = sw_wdata[ADDR_W-1:0];
              RA_LOCAL: local_d = sw_wdata[ADDR_W-1:0];
              RA_COUNT: count_d = sw_wdata[CNT_W-1:0];
              RA_LINK:  link_d  = sw_wdata;
              default: ;
            endcase
          end
        end
        ST_FETCH: begin
          if (run_en && mem_ack) begin
            unique case (widx_q)
              2'd0: host_d  = mem_rdata[ADDR_W-1:0];
              2'd1: local_d = mem_rdata[ADDR_W-1:0];
              2'd2: count_d = mem_rdata[CNT_W-1:0];
              default: link_d = mem_rdata;
            endcase
            if (widx_q == 2'd3) state_d = ST_CHECK;
            else                widx_d  = widx_q + 2'd1;
          end
        end
        ST_CHECK: begin
          if (run_en) state_d = (count_q == '0) ? end_state : ST_READ;
        end
        ST_READ: begin
          if (run_en && mem_ack) begin
            data_d  = mem_rdata;
            state_d = ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (run_en && mem_ack) begin
            host_d = host_q + STEP;
            if (!hold_local) local_d = local_q + STEP;
            if (count_q <= CSTEP) begin
              count_d = '0;
              state_d = end_state;
            end else begin
              count_d = count_q - CSTEP;
              state_d = ST_READ;
            end
          end
        end
        ST_ZERO: begin
          if (run_en && mem_ack) state_d = ST_NEXT;
        end
        ST_NEXT: begin
          if (run_en) begin
            link_hit = chain_mode && link_q[LB_LINK];
            if (!chain_mode || link_q[LB_LAST]) begin
              fin     = 1'b1;
              state_d = ST_IDLE;
            end else begin
              desc_d   = link_q[ADDR_W-1:4];
              dspace_d = link_q[LB_SPACE];
              widx_d   = 2'd0;
              state_d  = ST_FETCH;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_host  = 1'b0;
    mem_addr  = '0;
    mem_wdata = data_q;
    unique case (state_q)
      ST_FETCH: begin
        mem_req  = run_en;
        mem_host = dspace_q;
        mem_addr = {desc_q, widx_q, 2'b00};
      end
      ST_READ: begin
        mem_req  = run_en;
        mem_host = !dir;
        mem_addr = dir ? local_q : host_q;
      end
      ST_WRITE: begin
        mem_req  = run_en;
        mem_we   = 1'b1;
        mem_host = dir;
        mem_addr = dir ? host_q : local_q;
      end
      ST_ZERO: begin
        mem_req   = run_en;
        mem_we    = 1'b1;
        mem_host  = dspace_q;
        mem_addr  = {desc_q, 4'h8};
        mem_wdata = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      host_q   <= '0;
      local_q  <= '0;
      count_q  <= '0;
      link_q   <= '0;
      desc_q   <= '0;
      dspace_q <= 1'b0;
      widx_q   <= 2'd0;
      data_q   <= '0;
    end else begin
      state_q  <= state_d;
      host_q   <= host_d;
      local_q  <= local_d;
      count_q  <= count_d;
      link_q   <= link_d;
      desc_q   <= desc_d;
      dspace_q <= dspace_d;
      widx_q   <= widx_d;
      data_q   <= data_d;
    end
  end
endmodule

// File: rtl/chain_dma_csr.sv
module chain_dma_csr
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [RSEL_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                busy,
  input  logic                fin,
  input  logic                link_hit,
  input  logic [ADDR_W-1:0]   host_q,
  input  logic [ADDR_W-1:0]   local_q,
  input  logic [CNT_W-1:0]    count_q,
  input  logic [WORD_W-1:0]   link_q,
  output logic                go,
  output logic                stop,
  output logic                run_en,
  output logic                chain_mode,
  output logic                hold_local,
  output logic                zero_count,
  output logic                irq,
  output logic                done
);
  logic ctrl_wr, mode_wr;
  logic en_q, en_d;
  logic done_q, done_d;
  logic irq_q, irq_d;
  logic mchain_q, mdie_q, mhold_q, mzero_q;
  logic mchain_d, mdie_d, mhold_d, mzero_d;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign mode_wr = reg_wr && (reg_addr == RA_MODE) && !busy;
  assign go      = ctrl_wr && reg_wdata[CB_GO] && reg_wdata[CB_EN] &&
                   !reg_wdata[CB_ABORT] && !busy;
  assign stop    = ctrl_wr && reg_wdata[CB_ABORT] && busy;

  always_comb begin
    en_d     = en_q;
    done_d   = done_q;
    mchain_d = mchain_q;
    mdie_d   = mdie_q;
    mhold_d  = mhold_q;
    mzero_d  = mzero_q;
    if (ctrl_wr && !reg_wdata[CB_ABORT]) en_d = reg_wdata[CB_EN];
    if (go)                done_d = 1'b0;
    else if (fin || stop)  done_d = 1'b1;
    irq_d = ((fin && mdie_q) || link_hit) ||
            (irq_q && !(ctrl_wr && reg_wdata[CB_ICLR]));
    if (mode_wr) begin
      mchain_d = reg_wdata[MB_CHAIN];
      mdie_d   = reg_wdata[MB_DIE];
      mhold_d  = reg_wdata[MB_HOLD];
      mzero_d  = reg_wdata[MB_ZERO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      mchain_q <= 1'b0;
      mdie_q   <= 1'b0;
      mhold_q  <= 1'b0;
      mzero_q  <= 1'b0;
    end else begin
      en_q     <= en_d;
      done_q   <= done_d;
      irq_q    <= irq_d;
      mchain_q <= mchain_d;
      mdie_q   <= mdie_d;
      mhold_q  <= mhold_d;
      mzero_q  <= mzero_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_MODE: begin
        reg_rdata[MB_CHAIN] = mchain_q;
        reg_rdata[MB_DIE]   = mdie_q;
        reg_rdata[MB_HOLD]  = mhold_q;
        reg_rdata[MB_ZERO]  = mzero_q;
      end
      RA_HOST:  reg_rdata = WORD_W'(host_q);
      RA_LOCAL: reg_rdata = WORD_W'(local_q);
      RA_COUNT: reg_rdata = WORD_W'(count_q);
      RA_LINK:  reg_rdata = link_q;
      RA_CTRL: begin
        reg_rdata[CB_EN]   = en_q;
        reg_rdata[CB_DONE] = done_q;
      end
      default: ;
    endcase
  end

  assign run_en     = en_q;
  assign chain_mode = mchain_q;
  assign hold_local = mhold_q;
  assign zero_count = mzero_q;
  assign irq        = irq_q;
  assign done       = done_q;
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_host,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ack,
  input  logic [31:0]         mem_rdata,
  output logic                irq
);
  logic              busy, fin, link_hit, go, stop, run_en;
  logic              chain_mode, hold_local, zero_count, done;
  logic [ADDR_W-1:0] host_q, local_q;
  logic [CNT_W-1:0]  count_q;
  logic [WORD_W-1:0] link_q;

  chain_dma_csr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .fin        (fin),
    .link_hit   (link_hit),
    .host_q     (host_q),
    .local_q    (local_q),
    .count_q    (count_q),
    .link_q     (link_q),
    .go         (go),
    .stop       (stop),
    .run_en     (run_en),
    .chain_mode (chain_mode),
    .hold_local (hold_local),
    .zero_count (zero_count),
    .irq        (irq),
    .done       (done)
  );

  chain_dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .go         (go),
    .stop       (stop),
    .chain_mode (chain_mode),
    .hold_local (hold_local),
    .zero_count (zero_count),
    .sw_wr      (reg_wr),
    .sw_addr    (reg_addr),
    .sw_wdata   (reg_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .fin        (fin),
    .link_hit   (link_hit),
    .host_q     (host_q),
    .local_q    (local_q),
    .count_q    (count_q),
    .link_q     (link_q),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_host   (mem_host),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );
endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_host,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              irq,
  input logic              run_en,
  input logic              busy,
  input logic              done
);
  logic ctl_wr;
  assign ctl_wr = reg_wr && (reg_addr == RA_CTRL);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !ctl_wr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_host))); // R2
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !mem_req); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R10
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !done); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctl_wr && reg_wdata[CB_ICLR])) |=> irq); // R8
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_wr && reg_wdata[CB_ABORT]) |=> (!busy && done)); // R11
endmodule

bind chain_dma chain_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_host  (mem_host),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .irq       (irq),
  .run_en    (run_en),
  .busy      (busy),
  .done      (done)
);

// File: tb/chain_dma_bench.sv
`timescale 1ns/1ps
module chain_dma_bench;
  import chain_dma_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_host, irq;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  always #2 clk = ~clk;

  chain_dma u_chain_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_host(mem_host), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  typedef struct {
    bit          we;
    bit          host;
    logic [31:0] addr;
    logic [31:0] data;
    bit          cd;
    string       tag;
  } acc_t;

  acc_t        expq[$];
  logic [31:0] hmem[int];
  logic [31:0] lmem[int];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lat = 0;
  int wcnt = 0;
  int consumed = 0;
  bit hold_mem = 1'b0;
  bit paused = 1'b0;
  acc_t cur;

  function automatic logic [31:0] mrd(bit host, logic [31:0] a);
    if (host) return hmem.exists(int'(a)) ? hmem[int'(a)] : {a[15:0] ^ 16'h5A5A, 16'hB0B0};
    else      return lmem.exists(int'(a)) ? lmem[int'(a)] : {a[15:0] ^ 16'h3C3C, 16'h1010};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // memory model, per-clock comparison against the expected access stream
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (mem_ack) begin
        mem_ack = 1'b0;
        wcnt = 0;
        consumed++;
        if (cur.we) begin
          if (cur.host) hmem[int'(cur.addr)] = cur.data;
          else          lmem[int'(cur.addr)] = cur.data;
        end
        if (expq.size() == 0) begin
          chk(1'b0, "R2", "unexpected access addr", cur.addr, 32'h0);
        end else begin
          acc_t e;
          e = expq.pop_front();
          chk(cur.we == e.we && cur.host == e.host && cur.addr == e.addr, e.tag,
              "access kind/space/addr", {cur.we, cur.host, cur.addr[29:0]}, {e.we, e.host, e.addr[29:0]});
          if (e.cd) chk(cur.data == e.data, e.tag, "write data", cur.data, e.data);
        end
      end else if (mem_req && !hold_mem) begin
        if (wcnt >= lat) begin
          cur.we   = mem_we;
          cur.host = mem_host;
          cur.addr = mem_addr;
          cur.data = mem_wdata;
          mem_rdata = mem_we ? 32'h0 : mrd(mem_host, mem_addr);
          mem_ack = 1'b1;
        end else begin
          wcnt++;
        end
      end
      if (paused) chk(!mem_req, "R9", "request while paused", {31'h0, mem_req}, 32'h0);
      if (cyc > 150000) begin
        chk(1'b0, "WATCHDOG", "run did not finish", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] d;
    forever begin
      rd(RA_CTRL, d);
      if (d[CB_DONE]) break;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push(bit we, bit host, logic [31:0] a, logic [31:0] d, bit cd, string tag);
    acc_t e;
    e.we = we; e.host = host; e.addr = a; e.data = d; e.cd = cd; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic build_block(bit dir, logic [31:0] h, logic [31:0] l, int cnt, bit hold, string tag);
    int words;
    logic [31:0] ha, la;
    words = (cnt + 3) / 4;
    ha = h; la = l;
    for (int i = 0; i < words; i++) begin
      if (dir) begin
        push(1'b0, 1'b0, la, 32'h0, 1'b0, tag);
        push(1'b1, 1'b1, ha, mrd(1'b0, la), 1'b1, tag);
      end else begin
        push(1'b0, 1'b1, ha, 32'h0, 1'b0, tag);
        push(1'b1, 1'b0, la, mrd(1'b1, ha), 1'b1, tag);
      end
      ha = ha + 4;
      if (!hold) la = la + 4;
    end
  endtask

  task automatic build_chain(logic [31:0] ptr, bit zero, output bit any_link);
    logic [31:0] cur_p, base, h, l, c, n;
    bit sp;
    cur_p = ptr;
    any_link = 1'b0;
    forever begin
      base = {cur_p[31:4], 4'h0};
      sp = cur_p[0];
      for (int k = 0; k < 4; k++) push(1'b0, sp, base + 32'(k * 4), 32'h0, 1'b0, "R4");
      h = mrd(sp, base); l = mrd(sp, base + 4); c = mrd(sp, base + 8) & 32'h007F_FFFF;
      n = mrd(sp, base + 12);
      build_block(n[3], h, l, int'(c), 1'b0, "R2");
      if (zero) push(1'b1, sp, base + 8, 32'h0, 1'b1, "R6");
      if (n[2]) any_link = 1'b1;
      if (n[1]) break;
      cur_p = n;
    end
  endtask

  initial begin
    logic [31:0] d, c0;
    bit lk;
    int n0;
    idle(3);
    #1 rst_n = 1'b1;

    // reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk(d == 32'h0, "R1", "register after reset", d, 32'h0);
    end
    chk(!irq && !mem_req, "R1", "irq/req after reset", {irq, mem_req}, 32'h0);

    // unchained host->local, odd count, start repeated while busy
    lat = 0;
    wr(RA_HOST, 32'h1000); wr(RA_LOCAL, 32'h200); wr(RA_COUNT, 10); wr(RA_LINK, 32'h0);
    build_block(1'b0, 32'h1000, 32'h200, 10, 1'b0, "R2");
    wr(RA_CTRL, 32'h3);
    wr(RA_CTRL, 32'h3); // R10 start while busy
    wait_done();
    chk(expq.size() == 0, "R2", "words left", expq.size(), 0);
    rd(RA_HOST, d);  chk(d == 32'h100C, "R3", "host end", d, 32'h100C);
    rd(RA_LOCAL, d); chk(d == 32'h20C, "R3", "local end", d, 32'h20C);
    rd(RA_COUNT, d); chk(d == 0, "R3", "count end", d, 0);
    chk(!irq, "R8", "irq without enable", irq, 0);

    // local->host, hold local, done interrupt, write while busy ignored
    lat = 1;
    wr(RA_MODE, (32'h1 << MB_HOLD) | (32'h1 << MB_DIE));
    rd(RA_MODE, d); chk(d == 32'h0C00, "R12", "mode readback", d, 32'h0C00);
    wr(RA_HOST, 32'h2000); wr(RA_LOCAL, 32'h300); wr(RA_COUNT, 8); wr(RA_LINK, 32'h8);
    build_block(1'b1, 32'h2000, 32'h300, 8, 1'b1, "R3");
    wr(RA_CTRL, 32'h3);
    wr(RA_HOST, 32'hDEAD0000); // R12
    wr(RA_MODE, 32'h0);        // R12
    wait_done();
    chk(expq.size() == 0, "R3", "words left", expq.size(), 0);
    rd(RA_HOST, d);  chk(d == 32'h2008, "R12", "host after ignored write", d, 32'h2008);
    rd(RA_LOCAL, d); chk(d == 32'h300, "R3", "held local", d, 32'h300);
    rd(RA_MODE, d);  chk(d == 32'h0C00, "R12", "mode kept", d, 32'h0C00);
    chk(irq, "R8", "done interrupt", irq, 1);
    idle(3);
    chk(irq, "R8", "irq sticky", irq, 1);
    wr(RA_CTRL, 32'h8);
    #0.5 chk(!irq, "R8", "irq cleared", irq, 0);

    // zero count
    wr(RA_MODE, 32'h0); wr(RA_COUNT, 0);
    wr(RA_CTRL, 32'h3);
    wait_done();
    idle(5);
    chk(consumed > 0 && expq.size() == 0, "R3", "no access for zero count", expq.size(), 0);

    // 23-bit count
    lat = 2;
    wr(RA_HOST, 32'h4000); wr(RA_LOCAL, 32'h500); wr(RA_LINK, 32'h0);
    wr(RA_COUNT, 32'hFF80_0006);
    rd(RA_COUNT, d); chk(d == 32'h6, "R5", "count truncated", d, 32'h6);
    build_block(1'b0, 32'h4000, 32'h500, 6, 1'b0, "R5");
    wr(RA_CTRL, 32'h3);
    wait_done();
    chk(expq.size() == 0, "R5", "words left", expq.size(), 0);

    // chain of three descriptors across both spaces with zero-back
    lat = 1;
    hmem[32'h3000] = 32'h5000; hmem[32'h3004] = 32'h600; hmem[32'h3008] = 32'h0180_0008; hmem[32'h300C] = 32'h404;
    lmem[32'h400]  = 32'h5100; lmem[32'h404]  = 32'h700; lmem[32'h408]  = 32'h4;         lmem[32'h40C]  = 32'h3029;
    hmem[32'h3020] = 32'h5200; hmem[32'h3024] = 32'h800; hmem[32'h3028] = 32'h5;         hmem[32'h302C] = 32'h2;
    wr(RA_MODE, (32'h1 << MB_CHAIN) | (32'h1 << MB_ZERO));
    wr(RA_LINK, 32'h3001);
    build_chain(32'h3001, 1'b1, lk);
    wr(RA_CTRL, 32'h3);
    wait_done();
    chk(expq.size() == 0, "R4", "chain accesses left", expq.size(), 0);
    chk(hmem[32'h3008] == 0 && lmem[32'h408] == 0 && hmem[32'h3028] == 0, "R6", "counts zeroed",
        hmem[32'h3008] | lmem[32'h408] | hmem[32'h3028], 0);
    rd(RA_LINK, d); chk(d == 32'h2, "R4", "last link word", d, 32'h2);
    chk(irq == lk, "R8", "link interrupt", irq, lk);
    rd(RA_CTRL, d); chk(d[CB_DONE], "R7", "done after last element", d, 32'h11);
    wr(RA_CTRL, 32'h8);

    // start ignored without enable
    wr(RA_CTRL, 32'h2);
    idle(10);
    rd(RA_CTRL, d); chk(d == 32'h10, "R10", "start without enable ignored", d, 32'h10);
    chk(expq.size() == 0, "R10", "no traffic", expq.size(), 0);

    // pause and resume
    lat = 1;
    wr(RA_MODE, 32'h0);
    wr(RA_HOST, 32'h6000); wr(RA_LOCAL, 32'hA00); wr(RA_COUNT, 24); wr(RA_LINK, 32'h0);
    build_block(1'b0, 32'h6000, 32'hA00, 24, 1'b0, "R9");
    n0 = consumed;
    wr(RA_CTRL, 32'h3);
    rd(RA_CTRL, d); chk(d[CB_DONE] == 1'b0, "R7", "start clears done", d, 32'h1);
    while (consumed < n0 + 5) @(posedge clk);
    wr(RA_CTRL, 32'h0);
    paused = 1'b1;
    idle(2);
    rd(RA_COUNT, c0);
    idle(15);
    rd(RA_COUNT, d); chk(d == c0, "R9", "count frozen while paused", d, c0);
    paused = 1'b0;
    wr(RA_CTRL, 32'h1);
    wait_done();
    chk(expq.size() == 0, "R9", "resume completes", expq.size(), 0);

    // abort
    lat = 2;
    wr(RA_MODE, 32'h1 << MB_DIE);
    wr(RA_HOST, 32'h7000); wr(RA_LOCAL, 32'hC00); wr(RA_COUNT, 80);
    build_block(1'b0, 32'h7000, 32'hC00, 80, 1'b0, "R11");
    n0 = consumed;
    wr(RA_CTRL, 32'h3);
    while (consumed < n0 + 6) @(posedge clk);
    hold_mem = 1'b1;
    idle(3);
    wr(RA_CTRL, 32'h5);
    expq.delete();
    hold_mem = 1'b0;
    #0.5 chk(!mem_req, "R11", "request after abort", mem_req, 0);
    rd(RA_CTRL, d); chk(d == 32'h11, "R11", "done set, enable kept", d, 32'h11);
    idle(10);
    chk(!irq, "R8", "abort raises no irq", irq, 0);
    chk(expq.size() == 0, "R11", "no traffic after abort", expq.size(), 0);

    finish_run();
  end
endmodule